// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a single carry-in bit, producing a 16-bit sum and a carry-out. It is purely combinational. There are no registers, so a result is available in the same time step as its operands. The adder is one arithmetic leaf in a larger datapath. Callers drive the operands and the carry-in, then read the sum and carry-out once the logic settles.

The operand width is split into 4-bit groups. For every bit position, the block forms a propagate term (the XOR of the operand bits) and a generate term (the AND of the operand bits). Each group resolves its own internal carries with lookahead sum-of-products terms. Each group also reports a group propagate and a group generate.

A second-level lookahead unit takes the four group pairs and the external carry-in. From them it forms the carry entering each group boundary (bits 4, 8 and 12), plus the propagate and generate of the whole word. The carry-out is derived from that word-level pair and the carry-in. The word-level pair is also exported, so a wider adder could stack a further lookahead level on top.

Top module: `cla_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + carry_in`, with both operands read as unsigned numbers.
- R2: `carry_out` equals bit 16 of the 17-bit unsigned result `a_in + b_in + carry_in`.
- R3: `blk_prop` is 1 exactly when, at every bit position, one operand bit is 1 and the other is 0. Equivalently, `a_in + b_in` equals 0xFFFF.
- R4: `blk_gen` is 1 exactly when `a_in + b_in`, taken without the carry-in, is 0x10000 or more. `blk_prop` and `blk_gen` are never 1 together.
- R5: A carry crosses each 4-bit group boundary (into bits 4, 8 and 12). One case is a carry-in travelling through fully propagating low groups. For example, 0x000F + 0x0000 + 1 gives 0x0010, and 0x0FFF + 0x0000 + 1 gives 0x1000.
- R6: All-ones operands with a carry-in of 1 give a sum of 0xFFFF and a carry-out of 1. With a carry-in of 0 they give 0xFFFE and a carry-out of 1.
- R7: When every position propagates (for example 0xAAAA + 0x5555), the carry-in alone decides the result. A carry-in of 0 gives a sum of 0xFFFF and a carry-out of 0. A carry-in of 1 gives a sum of 0x0000 and a carry-out of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand, unsigned |
| b_in | input | 16 | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_prop | output | 1 | Word-level propagate: a carry-in would pass through all bits |
| blk_gen | output | 1 | Word-level generate: the operands alone produce a carry-out |

## Verification
The all-zero operand pattern shows that no stray carry or generate appears from nothing. Single-group all-propagate patterns with a carry-in show whether each second-level boundary carry (into bits 4, 8 and 12) is formed and routed to the right group. The all-ones and alternating-bit patterns separate the generate path from the pure propagate path of the word-level pair. Seeded random operands with both carry-in values then exercise mixed generate and propagate runs that the directed patterns do not.

// File: rtl/cla_pkg.sv
package cla_pkg;
    // Default data width and lookahead group size.
    localparam int DATA_W  = 16;
    localparam int GROUP_W = 4;
endpackage

// File: rtl/cla_bit_pg.sv
// Per-bit propagate and generate terms.
module cla_bit_pg #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] p_out,
    output logic [W-1:0] g_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign p_out[i] = a_in[i] ^ b_in[i];
        assign g_out[i] = a_in[i] & b_in[i];
    end
endmodule

// File: rtl/cla_lookahead.sv
// Generic N-input lookahead unit. It is used at both levels of the hierarchy.
// c_out[i] is the carry into position i (c_out[0] is the carry-in).
// p_grp/g_grp summarise the whole span for a higher level.
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] p_in,
    input  logic [N-1:0] g_in,
    input  logic         c_in,
    output logic [N-1:0] c_out,
    output logic         p_grp,
    output logic         g_grp
);
    // Each carry is a flat sum of products, not a chain through the
    // previous carry.
    always_comb begin
        logic acc;
        logic term;
        c_out[0] = c_in;
        for (int i = 1; i < N; i++) begin
            acc = c_in;
            for (int k = 0; k < i; k++) begin
                acc = acc & p_in[k];
            end
            for (int j = 0; j < i; j++) begin
                term = g_in[j];
                for (int k = j + 1; k < i; k++) begin
                    term = term & p_in[k];
                end
                acc = acc | term;
            end
            c_out[i] = acc;
        end
    end

    // Span generate: carry out of the span with no carry entering it.
    always_comb begin
        logic gacc;
        logic gterm;
        gacc = 1'b0;
        for (int j = 0; j < N; j++) begin
            gterm = g_in[j];
            for (int k = j + 1; k < N; k++) begin
                gterm = gterm & p_in[k];
            end
            gacc = gacc | gterm;
        end
        g_grp = gacc;
    end

    assign p_grp = &p_in;
endmodule

// File: rtl/cla_adder.sv
// Two-level carry-lookahead adder: groups of GROUP_W bits under one
// second-level lookahead unit.
module cla_adder #(
    parameter int WIDTH   = cla_pkg::DATA_W,
    parameter int GROUP_W = cla_pkg::GROUP_W
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             blk_prop,
    output logic             blk_gen
);
    localparam int NUM_GROUPS = WIDTH / GROUP_W;

    logic [WIDTH-1:0]      bit_p;
    logic [WIDTH-1:0]      bit_g;
    logic [WIDTH-1:0]      bit_c;
    logic [NUM_GROUPS-1:0] grp_p;
    logic [NUM_GROUPS-1:0] grp_g;
    logic [NUM_GROUPS-1:0] grp_c;

    cla_bit_pg #(.W(WIDTH)) u_pg (
        .a_in  (a_in),
        .b_in  (b_in),
        .p_out (bit_p),
        .g_out (bit_g)
    );

    // First level: one lookahead unit per group.
    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_group
        cla_lookahead #(.N(GROUP_W)) u_grp (
            .p_in  (bit_p[k*GROUP_W +: GROUP_W]),
            .g_in  (bit_g[k*GROUP_W +: GROUP_W]),
            .c_in  (grp_c[k]),
            .c_out (bit_c[k*GROUP_W +: GROUP_W]),
            .p_grp (grp_p[k]),
            .g_grp (grp_g[k])
        );
    end

    // Second level: boundary carries and the word-level pair.
    cla_lookahead #(.N(NUM_GROUPS)) u_top (
        .p_in  (grp_p),
        .g_in  (grp_g),
        .c_in  (carry_in),
        .c_out (grp_c),
        .p_grp (blk_prop),
        .g_grp (blk_gen)
    );

    assign carry_out = blk_gen | (blk_prop & carry_in);
    assign sum_out   = bit_p ^ bit_c;
endmodule

// File: rtl/cla_adder_chk.sv
// Checker bound to cla_adder; relates the ports to unsigned arithmetic.
module cla_adder_chk #(
    parameter int WIDTH = cla_pkg::DATA_W
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             blk_prop,
    input logic             blk_gen
);
    logic [WIDTH:0] full_sum;
    logic [WIDTH:0] raw_sum;
    logic           known;

    assign raw_sum  = {1'b0, a_in} + {1'b0, b_in};
    assign full_sum = raw_sum + {{WIDTH{1'b0}}, carry_in};
    assign known    = !$isunknown({a_in, b_in, carry_in});

    always_comb begin
        if (known) begin
            // R1 / R2
            a_r1_sum_value: assert ({carry_out, sum_out} == full_sum)
                else $error("sum or carry-out differs from a+b+cin");
            // R3
            a_r3_block_prop: assert (blk_prop == (raw_sum == {1'b0, {WIDTH{1'b1}}}))
                else $error("block propagate wrong");
            // R4
            a_r4_block_gen: assert (blk_gen == raw_sum[WIDTH])
                else $error("block generate wrong");
            // R4
            a_r4_pg_exclusive: assert (!(blk_prop && blk_gen))
                else $error("propagate and generate both set");
        end
    end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .blk_prop  (blk_prop),
    .blk_gen   (blk_gen)
);

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         blk_prop;
    logic         blk_gen;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder u_dut (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .blk_prop  (blk_prop),
        .blk_gen   (blk_gen)
    );

    task automatic check1(input string req, input logic [W:0] got, input logic [W:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // Drive away from the rising edge and compare every output.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        logic [W:0] raw;
        logic [W:0] full;
        @(negedge clk);
        a_in = a; b_in = b; carry_in = c;
        #1;
        raw  = {1'b0, a} + {1'b0, b};
        full = raw + {{W{1'b0}}, c};
        check1("R1 sum",       {1'b0, sum_out},   {1'b0, full[W-1:0]});
        check1("R2 carry_out", {{W{1'b0}}, carry_out}, {{W{1'b0}}, full[W]});
        check1("R3 blk_prop",  {{W{1'b0}}, blk_prop},
               {{W{1'b0}}, (raw == {1'b0, {W{1'b1}}})});
        check1("R4 blk_gen",   {{W{1'b0}}, blk_gen},  {{W{1'b0}}, raw[W]});
    endtask

    // Zero operands: no stray carry (R1, R2, R3, R4).
    task automatic t_zero();
        apply(16'h0000, 16'h0000, 1'b0);
        check1("R1 zero sum", {1'b0, sum_out}, 17'h0);
        apply(16'h0000, 16'h0000, 1'b1);
        check1("R1 zero+cin", {1'b0, sum_out}, 17'h1);
    endtask

    // Carry-in travelling through propagating low groups (R5).
    task automatic t_boundary();
        apply(16'h000F, 16'h0000, 1'b1);
        check1("R5 into bit4",  {1'b0, sum_out}, 17'h0010);
        apply(16'h00FF, 16'h0000, 1'b1);
        check1("R5 into bit8",  {1'b0, sum_out}, 17'h0100);
        apply(16'h0FFF, 16'h0000, 1'b1);
        check1("R5 into bit12", {1'b0, sum_out}, 17'h1000);
        apply(16'h0008, 16'h0008, 1'b0);
        check1("R5 gen at bit3", {1'b0, sum_out}, 17'h0010);
        apply(16'h0880, 16'h0080, 1'b0);
        check1("R5 gen at bit7", {1'b0, sum_out}, 17'h0900);
    endtask

    // All-ones operands (R6).
    task automatic t_all_ones();
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        check1("R6 sum cin1", {carry_out, sum_out}, 17'h1FFFF);
        apply(16'hFFFF, 16'hFFFF, 1'b0);
        check1("R6 sum cin0", {carry_out, sum_out}, 17'h1FFFE);
    endtask

    // Every position propagates (R7, R3).
    task automatic t_all_prop();
        apply(16'hAAAA, 16'h5555, 1'b0);
        check1("R7 prop cin0", {carry_out, sum_out}, 17'h0FFFF);
        check1("R3 prop set",  {16'h0, blk_prop}, 17'h1);
        apply(16'hAAAA, 16'h5555, 1'b1);
        check1("R7 prop cin1", {carry_out, sum_out}, 17'h10000);
        apply(16'h1234, 16'hEDCB, 1'b1);
        check1("R7 prop mixed", {carry_out, sum_out}, 17'h10000);
    endtask

    // Word generate without carry-in help (R4).
    task automatic t_generate();
        apply(16'h8000, 16'h8000, 1'b0);
        check1("R4 gen msb", {16'h0, blk_gen}, 17'h1);
        apply(16'h7FFF, 16'h8000, 1'b1);
        check1("R4 no gen", {16'h0, blk_gen}, 17'h0);
    endtask

    // Seeded random operands, both carry-in values (R1, R2).
    task automatic t_random();
        int unsigned seed = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            apply(W'($urandom(seed)), W'($urandom()), 1'(i & 1));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check1("R1 reset sum", {carry_out, sum_out}, 17'h0);
        t_zero();
        t_boundary();
        t_all_ones();
        t_all_prop();
        t_generate();
        t_random();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule